// File: doc/BRIEF.md
# Two-Way Integer Issue Pairing Unit

This unit sits at the tail of the decode stage of an in-order integer core that has two ALUs sharing one register file. Every cycle the decoder offers an older and a younger instruction, each with its own valid bit. The unit decides whether the two may leave together: the older one goes to issue port 0 and the younger one to issue port 1. When they may not, both go through port 0, the older one first and the younger one on the next cycle. During that split the unit holds the decoder through a ready line.

When the older slot holds a branch, the younger slot is discarded and a squash flag marks the bubble. All issue outputs and the squash flag are registered, so they appear one clock after the decoder presents the pair. The ready line is combinational, so the decoder can hold its pair in the same cycle.

Top module: `pair_dispatch`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, both issue ports are invalid and the squash flag is low, whatever the inputs. An idle port always drives all-zero fields.
- R2: A valid ALU/ALU pair with no conflict appears in the next cycle with the older one on port 0 and the younger one on port 1. `dec_ready` stays high. An older instruction that reads its own destination does not prevent pairing.
- R3: Pairing is refused when either source of the younger one equals the destination of the older one. A younger one that writes a register the older one only reads still pairs.
- R4: Pairing is refused when both instructions write the same destination register.
- R5: The class field is encoded as 0 = ALU, 1 = branch, 2 = memory, 3 = system. Only a pair in which both are class 0 may use port 1. Every other pair of two valid slots is split, unless the older slot is a branch.
- R6: When a pair is split, `dec_ready` is low for that one cycle only. Port 0 then shows the older instruction in the next cycle and the younger one in the cycle after that. Port 1 is idle in both cycles.
- R7: A valid older branch issues alone on port 0, with no split and `dec_ready` high. `yng_squash` is high alongside it exactly when the younger slot was valid.
- R8: With only the younger slot valid, it issues alone on port 0. With no slot valid, nothing issues.
- R9: An invalid younger slot never blocks the older one, whatever its fields hold.
- R10: A reset that arrives while a split is pending drops the held younger instruction, so it is never issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 2 | Older class (0 ALU, 1 branch, 2 memory, 3 system) |
| old_src_a | input | 2 | Older first source register |
| old_src_b | input | 2 | Older second source register |
| old_dst | input | 2 | Older destination register |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 2 | Younger class |
| yng_src_a | input | 2 | Younger first source register |
| yng_src_b | input | 2 | Younger second source register |
| yng_dst | input | 2 | Younger destination register |
| dec_ready | output | 1 | Low while the decoder must hold its pair |
| iss0_vld | output | 1 | Port 0 carries an instruction |
| iss0_cls | output | 2 | Port 0 class |
| iss0_src_a | output | 2 | Port 0 first source |
| iss0_src_b | output | 2 | Port 0 second source |
| iss0_dst | output | 2 | Port 0 destination |
| iss1_vld | output | 1 | Port 1 carries an instruction |
| iss1_cls | output | 2 | Port 1 class |
| iss1_src_a | output | 2 | Port 1 first source |
| iss1_src_b | output | 2 | Port 1 second source |
| iss1_dst | output | 2 | Port 1 destination |
| yng_squash | output | 1 | Younger slot was discarded behind a branch |

## Verification
The bench aims at the hazard edges. It uses a read-after-write match on each source field in turn, a shared destination, and a write-after-read that must still pair. A comparator that looks at the wrong field would pair a dependent instruction or split an independent one. It runs back-to-back splits and splits caused by non-ALU classes, since a design that drops or repeats the held younger instruction shows the wrong contents on port 0 in the second cycle. It also covers a branch with and without a younger partner, an invalid younger slot whose fields would conflict, and a reset in the middle of a split. The last case catches a stale younger instruction that leaks out after reset.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  localparam int NREGS = 4;
  localparam int RW    = $clog2(NREGS);
  localparam int NSRC  = 2;
  localparam int NPORT = 2;
  localparam int CW    = 2;

  typedef enum logic [CW-1:0] {
    CLS_ALU    = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_MEM    = 2'd2,
    CLS_SYS    = 2'd3
  } cls_e;

  typedef struct packed {
    logic                      vld;
    cls_e                      cls;
    logic [NSRC-1:0][RW-1:0]   src;
    logic [RW-1:0]             dst;
  } ins_t;
endpackage

// File: rtl/pdu_hazard.sv
module pdu_hazard
  import pdu_pkg::*;
(
  input  ins_t older,
  input  ins_t younger,
  output logic pair_ok
);
  logic [NSRC-1:0] raw_hit;
  logic            waw_hit;
  logic            both_alu;

  for (genvar s = 0; s < NSRC; s++) begin : g_raw
    assign raw_hit[s] = (younger.src[s] == older.dst);
  end

  assign waw_hit  = (younger.dst == older.dst);
  assign both_alu = (older.cls == CLS_ALU) && (younger.cls == CLS_ALU);
  assign pair_ok  = both_alu && !(|raw_hit) && !waw_hit;
endmodule

// File: rtl/pdu_steer.sv
module pdu_steer
  import pdu_pkg::*;
(
  input  logic                  split_pend,
  input  ins_t                  held,
  input  ins_t                  older,
  input  ins_t                  younger,
  input  logic                  pair_ok,
  output ins_t [NPORT-1:0]      port,
  output logic                  squash,
  output logic                  start_split,
  output logic                  ready
);
  always_comb begin
    port        = '0;
    squash      = 1'b0;
    start_split = 1'b0;
    if (split_pend) begin
      port[0] = held;
    end else if (older.vld) begin
      port[0] = older;
      if (older.cls == CLS_BRANCH) begin
        squash = younger.vld;
      end else if (younger.vld) begin
        if (pair_ok) port[1] = younger;
        else         start_split = 1'b1;
      end
    end else if (younger.vld) begin
      port[0] = younger;
    end
    ready = !start_split;
  end
endmodule

// File: rtl/pdu_split_ctl.sv
module pdu_split_ctl
  import pdu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_split,
  input  ins_t younger,
  output logic split_pend,
  output ins_t held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      split_pend <= 1'b0;
      held       <= '0;
    end else begin
      split_pend <= start_split;
      if (start_split) held <= younger;
    end
  end
endmodule

// File: rtl/pdu_issue_reg.sv
module pdu_issue_reg
  import pdu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ins_t [NPORT-1:0] d_port,
  input  logic             d_squash,
  output ins_t [NPORT-1:0] q_port,
  output logic             q_squash
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) q_port[p] <= '0;
      else     q_port[p] <= d_port[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_squash <= 1'b0;
    else     q_squash <= d_squash;
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pdu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          old_vld,
  input  logic [CW-1:0] old_cls,
  input  logic [RW-1:0] old_src_a,
  input  logic [RW-1:0] old_src_b,
  input  logic [RW-1:0] old_dst,
  input  logic          yng_vld,
  input  logic [CW-1:0] yng_cls,
  input  logic [RW-1:0] yng_src_a,
  input  logic [RW-1:0] yng_src_b,
  input  logic [RW-1:0] yng_dst,
  output logic          dec_ready,
  output logic          iss0_vld,
  output logic [CW-1:0] iss0_cls,
  output logic [RW-1:0] iss0_src_a,
  output logic [RW-1:0] iss0_src_b,
  output logic [RW-1:0] iss0_dst,
  output logic          iss1_vld,
  output logic [CW-1:0] iss1_cls,
  output logic [RW-1:0] iss1_src_a,
  output logic [RW-1:0] iss1_src_b,
  output logic [RW-1:0] iss1_dst,
  output logic          yng_squash
);
  ins_t             older, younger, held;
  ins_t [NPORT-1:0] nxt_port, cur_port;
  logic             pair_ok, split_pend, start_split, nxt_squash;

  always_comb begin
    older.vld      = old_vld;
    older.cls      = cls_e'(old_cls);
    older.src[0]   = old_src_a;
    older.src[1]   = old_src_b;
    older.dst      = old_dst;
    younger.vld    = yng_vld;
    younger.cls    = cls_e'(yng_cls);
    younger.src[0] = yng_src_a;
    younger.src[1] = yng_src_b;
    younger.dst    = yng_dst;
  end

  pdu_hazard u_hazard (
    .older   (older),
    .younger (younger),
    .pair_ok (pair_ok)
  );

  pdu_steer u_steer (
    .split_pend  (split_pend),
    .held        (held),
    .older       (older),
    .younger     (younger),
    .pair_ok     (pair_ok),
    .port        (nxt_port),
    .squash      (nxt_squash),
    .start_split (start_split),
    .ready       (dec_ready)
  );

  pdu_split_ctl u_split (
    .clk         (clk),
    .rst         (rst),
    .start_split (start_split),
    .younger     (younger),
    .split_pend  (split_pend),
    .held        (held)
  );

  pdu_issue_reg u_oreg (
    .clk      (clk),
    .rst      (rst),
    .d_port   (nxt_port),
    .d_squash (nxt_squash),
    .q_port   (cur_port),
    .q_squash (yng_squash)
  );

  assign iss0_vld   = cur_port[0].vld;
  assign iss0_cls   = cur_port[0].cls;
  assign iss0_src_a = cur_port[0].src[0];
  assign iss0_src_b = cur_port[0].src[1];
  assign iss0_dst   = cur_port[0].dst;
  assign iss1_vld   = cur_port[1].vld;
  assign iss1_cls   = cur_port[1].cls;
  assign iss1_src_a = cur_port[1].src[0];
  assign iss1_src_b = cur_port[1].src[1];
  assign iss1_dst   = cur_port[1].dst;
endmodule

// File: rtl/pair_dispatch_chk.sv
module pair_dispatch_chk
  import pdu_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          dec_ready,
  input logic          iss0_vld,
  input logic [CW-1:0] iss0_cls,
  input logic [RW-1:0] iss0_dst,
  input logic          iss1_vld,
  input logic [CW-1:0] iss1_cls,
  input logic [RW-1:0] iss1_src_a,
  input logic [RW-1:0] iss1_src_b,
  input logic [RW-1:0] iss1_dst,
  input logic          yng_squash
);
  AST_PORT1_NEEDS_PORT0: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> iss0_vld); // R2
  AST_PORT1_NO_RAW: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> (iss1_src_a != iss0_dst) && (iss1_src_b != iss0_dst)); // R3
  AST_PORT1_NO_WAW: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> (iss1_dst != iss0_dst)); // R4
  AST_PORT1_ALU_ONLY: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> (iss0_cls == CLS_ALU) && (iss1_cls == CLS_ALU)); // R5
  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !dec_ready |=> dec_ready); // R6
  AST_SPLIT_SOLO: assert property (@(posedge clk) disable iff (rst)
    !dec_ready |=> iss0_vld && !iss1_vld); // R6
  AST_SQUASH_SOLO: assert property (@(posedge clk) disable iff (rst)
    yng_squash |-> iss0_vld && !iss1_vld && (iss0_cls == CLS_BRANCH)); // R7
endmodule

bind pair_dispatch pair_dispatch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_ready  (dec_ready),
  .iss0_vld   (iss0_vld),
  .iss0_cls   (iss0_cls),
  .iss0_dst   (iss0_dst),
  .iss1_vld   (iss1_vld),
  .iss1_cls   (iss1_cls),
  .iss1_src_a (iss1_src_a),
  .iss1_src_b (iss1_src_b),
  .iss1_dst   (iss1_dst),
  .yng_squash (yng_squash)
);

// File: tb/pair_dispatch_bench.sv
module pair_dispatch_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       old_vld, yng_vld;
  logic [1:0] old_cls, old_src_a, old_src_b, old_dst;
  logic [1:0] yng_cls, yng_src_a, yng_src_b, yng_dst;
  logic       dec_ready, iss0_vld, iss1_vld, yng_squash;
  logic [1:0] iss0_cls, iss0_src_a, iss0_src_b, iss0_dst;
  logic [1:0] iss1_cls, iss1_src_a, iss1_src_b, iss1_dst;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  pair_dispatch u_pair_dispatch (
    .clk(clk), .rst(rst),
    .old_vld(old_vld), .old_cls(old_cls), .old_src_a(old_src_a),
    .old_src_b(old_src_b), .old_dst(old_dst),
    .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_src_a(yng_src_a),
    .yng_src_b(yng_src_b), .yng_dst(yng_dst),
    .dec_ready(dec_ready),
    .iss0_vld(iss0_vld), .iss0_cls(iss0_cls), .iss0_src_a(iss0_src_a),
    .iss0_src_b(iss0_src_b), .iss0_dst(iss0_dst),
    .iss1_vld(iss1_vld), .iss1_cls(iss1_cls), .iss1_src_a(iss1_src_a),
    .iss1_src_b(iss1_src_b), .iss1_dst(iss1_dst),
    .yng_squash(yng_squash)
  );

  // instruction packing used by the bench: {valid, class, src_a, src_b, dst}
  function automatic logic [8:0] mk(input logic v, input logic [1:0] c,
                                    input logic [1:0] a, input logic [1:0] b,
                                    input logic [1:0] d);
    return {v, c, a, b, d};
  endfunction

  // slot code: 0 = idle port, 1 = older slot, 2 = younger slot
  typedef struct packed {
    logic [8:0] o;
    logic [8:0] y;
    logic       rdy;
    logic [1:0] p0;
    logic [1:0] p1;
    logic       sq;
    logic [1:0] p0b;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{mk(1,0,0,1,2), mk(1,0,3,0,1), 1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 4'd2},  // R2 independent
    '{mk(1,0,0,1,2), mk(1,0,2,3,0), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd3},  // R3 src_a RAW
    '{mk(1,0,0,1,2), mk(1,0,1,2,3), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd3},  // R3 src_b RAW
    '{mk(1,0,0,1,3), mk(1,0,0,2,3), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd4},  // R4 WAW
    '{mk(1,2,0,1,2), mk(1,0,3,3,1), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd5},  // R5 memory older
    '{mk(1,0,0,1,2), mk(1,1,3,3,0), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd5},  // R5 branch younger
    '{mk(1,1,1,2,0), mk(1,0,3,3,1), 1'b1, 2'd1, 2'd0, 1'b1, 2'd0, 4'd7},  // R7 squash
    '{mk(1,1,1,2,0), mk(0,0,3,3,1), 1'b1, 2'd1, 2'd0, 1'b0, 2'd0, 4'd7},  // R7 no partner
    '{mk(0,0,0,0,0), mk(1,0,1,2,3), 1'b1, 2'd2, 2'd0, 1'b0, 2'd0, 4'd8},  // R8 younger alone
    '{mk(1,0,0,1,2), mk(0,0,2,2,2), 1'b1, 2'd1, 2'd0, 1'b0, 2'd0, 4'd9},  // R9 invalid younger
    '{mk(0,0,0,0,0), mk(0,0,0,0,0), 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 4'd8},  // R8 empty
    '{mk(1,0,2,2,2), mk(1,0,0,1,3), 1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 4'd2},  // R2 self-read older
    '{mk(1,0,0,1,2), mk(1,0,3,3,0), 1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 4'd3},  // R3 WAR pairs
    '{mk(1,3,0,1,2), mk(1,3,3,3,1), 1'b0, 2'd1, 2'd0, 1'b0, 2'd2, 4'd5}   // R5 system pair
  };

  function automatic logic [8:0] pick(input logic [1:0] code,
                                      input logic [8:0] o, input logic [8:0] y);
    return (code == 2'd1) ? o : (code == 2'd2) ? y : 9'd0;
  endfunction

  task automatic drive(input logic [8:0] o, input logic [8:0] y);
    {old_vld, old_cls, old_src_a, old_src_b, old_dst} = o;
    {yng_vld, yng_cls, yng_src_a, yng_src_b, yng_dst} = y;
  endtask

  task automatic chk(input int req, input string what,
                     input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] port0();
    return {iss0_vld, iss0_cls, iss0_src_a, iss0_src_b, iss0_dst};
  endfunction
  function automatic logic [8:0] port1();
    return {iss1_vld, iss1_cls, iss1_src_a, iss1_src_b, iss1_dst};
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset wins over a pairable input
    drive(mk(1,0,0,1,2), mk(1,0,3,0,1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1, "reset port0", port0(), 9'd0);
    chk(1, "reset port1", port1(), 9'd0);
    chk(1, "reset squash", {8'd0, yng_squash}, 9'd0);
    rst = 1'b0;
    drive(9'd0, 9'd0);
    @(posedge clk); @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].o, TBL[i].y);
      #5;
      chk(int'(TBL[i].req), $sformatf("vec %0d ready", i), {8'd0, dec_ready}, {8'd0, TBL[i].rdy});
      @(posedge clk); @(negedge clk);
      chk(int'(TBL[i].req), $sformatf("vec %0d port0", i), port0(), pick(TBL[i].p0, TBL[i].o, TBL[i].y));
      chk(int'(TBL[i].req), $sformatf("vec %0d port1", i), port1(), pick(TBL[i].p1, TBL[i].o, TBL[i].y));
      chk(int'(TBL[i].req), $sformatf("vec %0d squash", i), {8'd0, yng_squash}, {8'd0, TBL[i].sq});
      if (!TBL[i].rdy) begin
        // R6 second cycle of a split
        #5;
        chk(6, $sformatf("vec %0d ready 2nd", i), {8'd0, dec_ready}, 9'd1);
        @(posedge clk); @(negedge clk);
        chk(6, $sformatf("vec %0d port0 2nd", i), port0(), pick(TBL[i].p0b, TBL[i].o, TBL[i].y));
        chk(6, $sformatf("vec %0d port1 2nd", i), port1(), 9'd0);
      end
    end

    // R10: reset during a pending split drops the held younger instruction
    drive(mk(1,0,0,1,2), mk(1,0,2,3,0));
    @(posedge clk); @(negedge clk);
    chk(10, "split start port0", port0(), mk(1,0,0,1,2));
    rst = 1'b1;
    drive(9'd0, 9'd0);
    @(posedge clk); @(negedge clk);
    chk(10, "in reset port0", port0(), 9'd0);
    rst = 1'b0;
    #5;
    chk(10, "ready after reset", {8'd0, dec_ready}, 9'd1);
    @(posedge clk); @(negedge clk);
    chk(10, "no stale younger", port0(), 9'd0);
    chk(10, "no stale port1", port1(), 9'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule